// File: doc/BRIEF.md
# Queue-Occupancy Attack-Decay Frequency Governor

This block sets the target frequency of one clock domain from the fill level of that domain's input queue. There is no software in the loop. A free-running interval counter divides time into fixed decision windows. At the end of each window the block samples the queue occupancy and compares it with the sample from the previous window.

A rise of at least a fixed fraction of the queue capacity counts as a burst. It pushes the target up by a step proportional to the current frequency. A level inside a programmable dead band, or any drop, lets the target decay by a small step. A rise that is above the dead band but below the burst fraction leaves the target where it is.

The target is an index into a table of equally spaced frequency-voltage working points. A downstream transition sequencer consumes it, together with a one-cycle strobe that marks each real change of the index.

Top module: `queue_freq_governor`

## Requirements
- R1: While `rst` is high, and after it is released until the first decision, `target_idx` equals NUM_POINTS-1 and `target_new` is 0.
- R2: A decision happens once every STEP_CYCLES clock cycles. The first one falls on the STEP_CYCLES-th rising edge after reset is released.
- R3: The first decision after reset only records the occupancy as the previous sample. `target_idx` and `target_new` do not change.
- R4: Attack: let rise = occupancy minus previous sample, with rise > 0 and rise*FILL_DIV >= `capacity`. The index then grows by floor((idx+BASE_STEPS)*ATTACK_Q8/256). This rule takes priority over the dead band.
- R5: Decay applies when the occupancy is equal to or below the previous sample, or has risen by less than `dead_band`. The index then shrinks by max(1, floor((idx+BASE_STEPS)*DECAY_Q12/4096)).
- R6: A rise that is at least `dead_band` but does not meet the attack condition leaves the index unchanged.
- R7: The index saturates at 0 and at NUM_POINTS-1.
- R8: `target_new` is high for exactly one cycle, and only in the cycle after a decision that changed `target_idx`.
- R9: Between decisions, `target_idx` holds and `target_new` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst | input | 1 | Synchronous reset, active high |
| occupancy | input | OCC_W | Current input queue fill count |
| capacity | input | OCC_W | Queue capacity used for the burst threshold |
| dead_band | input | OCC_W | Rise below which the level counts as steady |
| target_idx | output | $clog2(NUM_POINTS) | Requested working-point index |
| target_new | output | 1 | One-cycle pulse when `target_idx` changes |

## Verification
The bench builds the block with an 8-cycle decision window, 320 working points, an 8-bit occupancy and the default fixed-point gains. The short window means hundreds of decisions fit in a few thousand cycles. That is enough to decay all the way from the top index to the floor, and then attack upward from index 0. The capacity is 100, so the burst threshold is exactly a rise of 2 entries. This makes the boundary between hold and attack, and the rule that attack wins over a wide dead band, reachable with small occupancy values.

// File: rtl/queue_freq_governor.sv
module queue_freq_governor #(
  parameter int unsigned STEP_CYCLES = 50000,
  parameter int unsigned NUM_POINTS  = 320,
  parameter int unsigned OCC_W       = 10,
  parameter int unsigned BASE_STEPS  = 107,
  parameter int unsigned ATTACK_Q8   = 15,
  parameter int unsigned DECAY_Q12   = 8,
  parameter int unsigned FILL_DIV    = 50
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [OCC_W-1:0]              occupancy,
  input  logic [OCC_W-1:0]              capacity,
  input  logic [OCC_W-1:0]              dead_band,
  output logic [$clog2(NUM_POINTS)-1:0] target_idx,
  output logic                          target_new
);
  localparam int unsigned IDX_W   = $clog2(NUM_POINTS);
  localparam int unsigned CNT_W   = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [31:0] MAX_IDX = 32'(NUM_POINTS - 1);

  logic [CNT_W-1:0] cnt;
  logic [OCC_W-1:0] prev;
  logic             primed;
  logic             tick;
  logic [31:0]      idx32, fs, atk, dec_raw, dec, rise, up, down, nxt;
  logic             rising, attack, hold;

  assign tick    = (cnt == CNT_W'(STEP_CYCLES - 1));
  assign idx32   = 32'(target_idx);
  assign fs      = idx32 + 32'(BASE_STEPS);
  assign atk     = (fs * ATTACK_Q8) >> 8;
  assign dec_raw = (fs * DECAY_Q12) >> 12;
  assign dec     = (dec_raw == 32'd0) ? 32'd1 : dec_raw;

  assign rising  = occupancy > prev;
  assign rise    = 32'(occupancy) - 32'(prev);
  assign attack  = rising && (rise * FILL_DIV >= 32'(capacity));
  assign hold    = rising && !attack && (rise >= 32'(dead_band));

  assign up      = (idx32 + atk > MAX_IDX) ? MAX_IDX : idx32 + atk;
  assign down    = (dec > idx32) ? 32'd0 : idx32 - dec;
  assign nxt     = attack ? up : (hold ? idx32 : down);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      prev       <= '0;
      primed     <= 1'b0;
      target_idx <= IDX_W'(MAX_IDX);
      target_new <= 1'b0;
    end else begin
      target_new <= 1'b0;
      cnt        <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        prev   <= occupancy;
        primed <= 1'b1;
        if (primed) begin
          target_idx <= IDX_W'(nxt);
          target_new <= (IDX_W'(nxt) != target_idx);
        end
      end
    end
  end

  a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    32'(target_idx) <= MAX_IDX);

  a_r8_strobe_implies_change: assert property (@(posedge clk) disable iff (rst)
    target_new |-> (target_idx != $past(target_idx)));

  a_r8_change_implies_strobe: assert property (@(posedge clk) disable iff (rst)
    (target_idx != $past(target_idx)) |-> target_new);

  a_r8_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    (target_new && STEP_CYCLES > 1) |=> !target_new);

  a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(target_idx));

  a_r3_first_sample_silent: assert property (@(posedge clk) disable iff (rst)
    !primed |=> !target_new);
endmodule

// File: tb/queue_freq_governor_tb_top.sv
module queue_freq_governor_tb_top;
  localparam int STEP = 8;
  localparam int NPTS = 320;
  localparam int OW   = 8;
  localparam int NV   = 8;
  // 3 = first sample, 1 = attack, 0 = hold, 2 = decay
  localparam int OCC_V[NV] = '{10, 10, 12, 13, 13, 5, 5, 6};
  localparam int ACT_V[NV] = '{3, 2, 1, 0, 2, 2, 2, 0};

  logic          clk = 1'b0;
  logic          rst;
  logic [OW-1:0] occupancy, capacity, dead_band;
  logic [8:0]    target_idx;
  logic          target_new;
  int n_chk = 0, n_fail = 0, exp_idx;
  bit done = 0;

  always #10 clk = ~clk;

  queue_freq_governor #(.STEP_CYCLES(STEP), .NUM_POINTS(NPTS), .OCC_W(OW)) dut_i (
    .clk(clk), .rst(rst), .occupancy(occupancy), .capacity(capacity),
    .dead_band(dead_band), .target_idx(target_idx), .target_new(target_new));

  function automatic int model(int idx, int act);
    int fs, d;
    fs = idx + 107;
    if (act == 1) begin
      d = idx + (fs * 15) / 256;
      return (d > NPTS - 1) ? NPTS - 1 : d;
    end else if (act == 2) begin
      d = (fs * 8) / 4096;
      if (d == 0) d = 1;
      return (idx - d < 0) ? 0 : idx - d;
    end
    return idx;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge after the decision
  task automatic step(int occ, int act, string req);
    int old;
    old = exp_idx;
    occupancy = OW'(occ);
    repeat (STEP - 2) @(posedge clk);
    #1;
    check("R9 idx mid-window", int'(target_idx), old);
    check("R9 strobe mid-window", int'(target_new), 0);
    repeat (2) @(posedge clk);
    #1;
    if (act != 3) exp_idx = model(old, act);
    check(req, int'(target_idx), exp_idx);
    check({req, " strobe (R8)"}, int'(target_new), (exp_idx != old) ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; occupancy = '0; capacity = 8'd100; dead_band = 8'd1;
    exp_idx = NPTS - 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset idx", int'(target_idx), NPTS - 1);
    check("R1 reset strobe", int'(target_new), 0);
    @(negedge clk);
    rst = 1'b0;
    // table walk: R2 timing, R3 first sample, R4/R5/R6 rules, R7 top clip
    for (int i = 0; i < NV; i++)
      step(OCC_V[i], ACT_V[i], (ACT_V[i] == 3) ? "R3 first sample" :
           (ACT_V[i] == 1) ? "R4/R7 attack" : (ACT_V[i] == 0) ? "R6 hold" : "R5 decay");
    dead_band = 8'd3;
    step(8, 1, "R4 attack beats dead band");
    step(0, 2, "R5 drop decays");
    for (int i = 0; i < 340; i++) step(0, 2, "R7 floor decay");
    check("R7 floor reached", int'(target_idx), 0);
    step(2, 1, "R4 attack from floor");
    step(4, 1, "R4 second attack");
    check("R4 index after two attacks", int'(target_idx), 12);
    step(5, 2, "R5 small rise inside dead band");
    step(6, 2, "R5 second small rise");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule